// File: doc/BRIEF.md
# DDR SDRAM Start-up and Refresh Sequencer

This block brings a DDR SDRAM out of power-up and then keeps it refreshed. After reset it holds the clock-enable pin low for a programmable settling time. The settling time is given in picoseconds and turned into a cycle count, so a simulation can shrink it to a few tens of nanoseconds. The block then raises clock-enable and spends one cycle on a NOP. After that it plays a fixed command script: precharge of all banks, extended mode load, mode load with DLL reset, a second precharge, two auto-refreshes, and a final mode load without DLL reset. Each command is followed by a parameterised number of NOP cycles.

Once the script has finished, `init_done_o` rises and stays high. A refresh interval counter then starts. Each time it expires, it raises `refresh_req_o`. A controller sitting beside this block answers with `refresh_ack_i` when the command bus is free. The sequencer then drives one AUTO REFRESH command itself, followed by the refresh recovery NOPs.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_ni` is low: `cke_o` is 0, `cs_no` is 1, `init_done_o` is 0 and `refresh_req_o` is 0.
- R2: After reset is released, `cke_o` stays 0 and `cs_no` stays 1 for exactly INIT_CYC = ceil(INIT_TIME_PS / CLK_PERIOD_PS) cycles. `init_done_o` stays 0 during that time.
- R3: In the first cycle with `cke_o` high, the command is NOP: `cs_no`=0 and {`ras_no`,`cas_no`,`we_no`}=111. `cke_o` never falls again before the next reset.
- R4: The cycle after that NOP, the script starts. Command codes for {ras,cas,we} are: precharge 010, mode load 000, refresh 001. The order is:
  - precharge-all (A10=1, BA=0)
  - mode load with BA=1 and A=0
  - mode load with BA=0 and DLL reset
  - precharge-all
  - refresh
  - refresh
  - mode load with BA=0 without DLL reset
- R5: After each script command the bus carries NOPs for the matching gap before the next command is issued. The gap is T_RP_CYC after a precharge, T_MRD_CYC after a mode load, and T_RFC_CYC after a refresh. The next command comes in the cycle right after the gap.
- R6: The BA=0 mode value has these fields:
  - A[2:0]=001 (burst of two)
  - A3=0
  - A[6:4] = CAS latency (2 or 3, set by CAS_LAT)
  - A8 = DLL reset
  - all other bits 0
- R7: `init_done_o` rises in the cycle right after the last NOP of the final mode load's gap. It stays high until the next reset.
- R8: `refresh_req_o` first rises REFI_CYC cycles after `init_done_o` rises. It rises again every REFI_CYC cycles after that.
- R9: `refresh_req_o` stays high until `refresh_ack_i` is sampled high. An acknowledge while no request is pending does nothing: no command is issued and no request appears.
- R10: On the clock edge where the request and the acknowledge are both high, the request clears and the bus carries an AUTO REFRESH (001) in that same cycle. T_RFC_CYC NOP cycles follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_ack_i | input | 1 | Controller grants a pending refresh |
| cke_o | output | 1 | SDRAM clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode value |
| init_done_o | output | 1 | Start-up script complete |
| refresh_req_o | output | 1 | Refresh interval expired |

## Verification
The bench gives three different gap lengths, so that a script step timed with the wrong gap lands on the wrong cycle. It also uses a start-up time that is not a whole number of clock periods, so that rounding down is caught. Refresh is tried three ways:
- with an immediate acknowledge, which shows the request clearing and the refresh command appearing in the same cycle;
- with a held-off acknowledge, which separates a latched request from a one-cycle pulse;
- with a stray acknowledge and no request pending, which must produce no command.

A second instance with CAS latency 2 shows the latency reaching the mode field.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  // {ras_n, cas_n, we_n} with cs_n low
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    S_WAIT, S_NOP, S_CMD, S_GAP, S_DONE, S_AREF, S_ARFC
  } seq_state_e;

  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned STEP_W    = 3;
endpackage

// File: rtl/ddr_down_timer.sv
module ddr_down_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= W'(RST_VAL);
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int unsigned PERIOD = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic req_o
);
  localparam int unsigned RW = $clog2(PERIOD + 1);
  localparam logic [RW-1:0] RELOAD = RW'(PERIOD - 1);

  logic [RW-1:0] cnt_q;
  logic          req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      req_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= RELOAD;
      req_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= RELOAD;
      req_q <= 1'b1;          // expiry wins over a same-cycle grant
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (clr_i) req_q <= 1'b0;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10_000,
  parameter int unsigned INIT_TIME_PS  = 200_000_000,
  parameter int unsigned CAS_LAT       = 3,
  parameter int unsigned T_RP_CYC      = 2,
  parameter int unsigned T_MRD_CYC     = 2,
  parameter int unsigned T_RFC_CYC     = 8,
  parameter int unsigned REFI_CYC      = 780,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              refresh_ack_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              refresh_req_o
);
  localparam int unsigned INIT_RAW = (INIT_TIME_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned INIT_CYC = (INIT_RAW < 1) ? 1 : INIT_RAW;
  localparam int unsigned GAP_A    = (T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC;
  localparam int unsigned MAX_GAP  = (GAP_A > T_RFC_CYC) ? GAP_A : T_RFC_CYC;
  localparam int unsigned MAX_CNT  = (INIT_CYC > MAX_GAP) ? INIT_CYC : MAX_GAP;
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [2:0]  CL_CODE  = (CAS_LAT == 2) ? 3'd2 : 3'd3;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              tmr_load, tmr_zero, grant;
  logic [CNT_W-1:0]  tmr_val;
  ddr_cmd_e          step_cmd, cmd;
  logic [BA_W-1:0]   step_ba;
  logic [ADDR_W-1:0] step_addr;
  logic [CNT_W-1:0]  step_gap;

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = 3'b001;
    w[6:4] = CL_CODE;
    w[8]   = dll_rst;
    return w;
  endfunction

  // script table
  always_comb begin
    step_cmd  = CMD_LMR;
    step_ba   = '0;
    step_addr = '0;
    step_gap  = CNT_W'(T_MRD_CYC);
    unique case (step_q)
      3'd0, 3'd3: begin
        step_cmd      = CMD_PRE;
        step_addr[10] = 1'b1;
        step_gap      = CNT_W'(T_RP_CYC);
      end
      3'd1: step_ba   = BA_W'(1);
      3'd2: step_addr = mode_word(1'b1);
      3'd4, 3'd5: begin
        step_cmd = CMD_REF;
        step_gap = CNT_W'(T_RFC_CYC);
      end
      default: step_addr = mode_word(1'b0);
    endcase
  end

  assign grant = (state_q == S_DONE) && refresh_req_o && refresh_ack_i;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = step_gap - 1'b1;
    unique case (state_q)
      S_WAIT: if (tmr_zero) state_d = S_NOP;
      S_NOP:  state_d = S_CMD;
      S_CMD: begin
        tmr_load = 1'b1;
        state_d  = S_GAP;
      end
      S_GAP: if (tmr_zero) begin
        if (step_q == STEP_W'(NUM_STEPS - 1)) state_d = S_DONE;
        else begin
          step_d  = step_q + 1'b1;
          state_d = S_CMD;
        end
      end
      S_DONE: if (grant) state_d = S_AREF;
      S_AREF: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFC_CYC - 1);
        state_d  = S_ARFC;
      end
      S_ARFC: if (tmr_zero) state_d = S_DONE;
      default: state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_WAIT;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  ddr_down_timer #(.W(CNT_W), .RST_VAL(INIT_CYC - 1)) u_gap_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign init_done_o = (state_q == S_DONE) || (state_q == S_AREF) || (state_q == S_ARFC);

  ddr_refresh_timer #(.PERIOD(REFI_CYC)) u_refi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .clr_i  (grant),
    .req_o  (refresh_req_o)
  );

  always_comb begin
    cmd = CMD_NOP;
    if (state_q == S_CMD)       cmd = step_cmd;
    else if (state_q == S_AREF) cmd = CMD_REF;
  end

  assign cke_o  = (state_q != S_WAIT);
  assign cs_no  = (state_q == S_WAIT);
  assign ras_no = cmd[2];
  assign cas_no = cmd[1];
  assign we_no  = cmd[0];
  assign ba_o   = (state_q == S_CMD) ? step_ba   : '0;
  assign addr_o = (state_q == S_CMD) ? step_addr : '0;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic refresh_ack_i,
  input logic cke_o,
  input logic cs_no,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic init_done_o,
  input logic refresh_req_o
);
  p_deselect_while_cke_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cs_no);

  p_nop_on_cke_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (!cs_no && ras_no && cas_no && we_no));

  p_cke_stays_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_done_needs_cke_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> cke_o);

  p_req_only_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |-> init_done_o);

  p_req_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_req_o && !refresh_ack_i) |=> refresh_req_o);

  p_ref_on_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(refresh_req_o) |-> (!cs_no && !ras_no && !cas_no && we_no));
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (.*);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int CLK_PS  = 10_000;
  localparam int INIT_PS = 45_000;   // 4.5 periods -> 5 cycles
  localparam int TRP     = 2;
  localparam int TMRD    = 3;
  localparam int TRFC    = 5;
  localparam int REFI    = 40;
  localparam int INIT_CYC = (INIT_PS + CLK_PS - 1) / CLK_PS;

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    int          cyc;
    string       req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni, ack;
  logic cke, cs_n, ras_n, cas_n, we_n, done, req;
  logic [1:0] ba;
  logic [12:0] addr;
  logic cke1, cs1, ras1, cas1, we1, done1, req1;
  logic [1:0] ba1;
  logic [12:0] addr1;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  exp_t q[$];

  always #5ns clk_i = ~clk_i;

  ddr_init_seq #(.CLK_PERIOD_PS(CLK_PS), .INIT_TIME_PS(INIT_PS), .CAS_LAT(3),
    .T_RP_CYC(TRP), .T_MRD_CYC(TMRD), .T_RFC_CYC(TRFC), .REFI_CYC(REFI)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .refresh_ack_i(ack), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ba_o(ba), .addr_o(addr),
    .init_done_o(done), .refresh_req_o(req));

  ddr_init_seq #(.CLK_PERIOD_PS(CLK_PS), .INIT_TIME_PS(INIT_PS), .CAS_LAT(2),
    .T_RP_CYC(TRP), .T_MRD_CYC(TMRD), .T_RFC_CYC(TRFC), .REFI_CYC(REFI)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .refresh_ack_i(1'b0), .cke_o(cke1), .cs_no(cs1),
    .ras_no(ras1), .cas_no(cas1), .we_no(we1), .ba_o(ba1), .addr_o(addr1),
    .init_done_o(done1), .refresh_req_o(req1));

  always @(posedge clk_i) cyc <= rst_ni ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mode_val(input int cl, input bit dll);
    return 13'(1 | (cl << 4) | (int'(dll) << 8));
  endfunction

  task automatic push(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                      input int at, input string rq);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.cyc = at; e.req = rq;
    q.push_back(e);
  endtask

  // driver: expected start-up script, returns cycle where init_done rises
  task automatic push_script(output int done_at);
    int k;
    k = INIT_CYC + 1;
    push(3'b010, 2'd0, 13'h400, k, "R4");            k += 1 + TRP;
    push(3'b000, 2'd1, 13'h000, k, "R4");            k += 1 + TMRD;
    push(3'b000, 2'd0, mode_val(3, 1'b1), k, "R6");  k += 1 + TMRD;
    push(3'b010, 2'd0, 13'h400, k, "R5");            k += 1 + TRP;
    push(3'b001, 2'd0, 13'h000, k, "R5");            k += 1 + TRFC;
    push(3'b001, 2'd0, 13'h000, k, "R5");            k += 1 + TRFC;
    push(3'b000, 2'd0, mode_val(3, 1'b0), k, "R6");
    done_at = k + TMRD + 1;
  endtask

  // monitor: every non-NOP command of u0 must match the queue head
  always @(negedge clk_i) begin
    if (rst_ni && !cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected command", {ras_n, cas_n, we_n}, 3'b111);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({ras_n, cas_n, we_n} == e.cmd, e.req, "command code", {ras_n, cas_n, we_n}, e.cmd);
        chk(ba == e.ba && addr == e.addr, e.req, "bank/address", {ba, addr}, {e.ba, e.addr});
        chk(cyc == e.cyc, e.req, "command cycle", cyc, e.cyc);
      end
    end
  end

  // CAS latency 2 instance: mode field check
  always @(negedge clk_i) begin
    if (rst_ni && !cs1 && {ras1, cas1, we1} == 3'b000 && ba1 == 2'd0)
      chk(addr1[6:4] == 3'd2 && addr1[2:0] == 3'b001 && addr1[3] == 1'b0, "R6",
          "CL2 mode value", addr1, mode_val(2, addr1[8]));
  end

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk_i);
    chk(1'b0, "R0", "watchdog expired", cyc, 0);
    finish_run();
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  task automatic serve_refresh(input int hold);
    repeat (hold) begin
      @(negedge clk_i);
      chk(req == 1'b1, "R9", "request held without ack", req, 1);
    end
    ack = 1'b1;
    push(3'b001, 2'd0, 13'h000, cyc + 1, "R10");
    @(negedge clk_i);
    ack = 1'b0;
    chk(req == 1'b0, "R10", "request cleared by grant", req, 0);
  endtask

  initial begin
    int done_at;
    bit ok;
    rst_ni = 1'b0;
    ack    = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!cke && cs_n && !done && !req, "R1", "reset outputs", {cke, cs_n, done, req}, 4'b0100);

    push_script(done_at);
    rst_ni = 1'b1;
    ok = 1'b1;
    for (int c = 0; c < INIT_CYC; c++) begin
      if (cke || !cs_n || done) ok = 1'b0;
      @(negedge clk_i);
    end
    chk(ok, "R2", "cke low/deselect during wait", ok, 1);
    chk(cyc == INIT_CYC && cke, "R2", "cke rise cycle", cyc, INIT_CYC);
    chk(!cs_n && {ras_n, cas_n, we_n} == 3'b111, "R3", "first cycle is NOP",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);

    wait_cyc(done_at - 1);
    chk(done == 1'b0, "R7", "init_done before end", done, 0);
    @(negedge clk_i);
    chk(done == 1'b1, "R7", "init_done rise", done, 1);
    chk(q.size() == 0, "R4", "script fully issued", q.size(), 0);

    // first request, immediate ack
    wait_cyc(done_at + REFI - 1);
    chk(req == 1'b0, "R8", "request before interval", req, 0);
    @(negedge clk_i);
    chk(req == 1'b1, "R8", "first request", req, 1);
    serve_refresh(0);

    // stray ack with no request pending
    wait_cyc(done_at + REFI + 20);
    ack = 1'b1;
    @(negedge clk_i);
    ack = 1'b0;
    @(negedge clk_i);
    chk(req == 1'b0 && cs_n == 1'b0 && {ras_n, cas_n, we_n} == 3'b111, "R9",
        "stray ack ignored", {req, ras_n, cas_n, we_n}, 4'b0111);

    // second request, held-off ack
    wait_cyc(done_at + 2 * REFI - 1);
    chk(req == 1'b0, "R8", "second request early", req, 0);
    @(negedge clk_i);
    chk(req == 1'b1, "R8", "second request", req, 1);
    serve_refresh(3);

    wait_cyc(done_at + 3 * REFI);
    chk(req == 1'b1, "R8", "third request", req, 1);
    serve_refresh(0);
    repeat (TRFC + 2) @(negedge clk_i);
    chk(done == 1'b1 && cke == 1'b1, "R7", "init_done held", done, 1);
    chk(q.size() == 0, "R10", "refresh commands issued", q.size(), 0);

    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!cke && cs_n && !done && !req, "R1", "re-reset outputs", {cke, cs_n, done, req}, 4'b0100);
    finish_run();
  end
endmodule